// File: doc/BRIEF.md
# Dual-Bank Register File with Cross-Side Access

This block holds two banks of general-purpose registers, called side A (index 0) and side B (index 1). Each bank has NREG entries of DW bits, 16 by 32 by default. Each side serves NPORT functional-unit ports, four by default. Every unit port has one read port and one write port. A per-unit select bit sends each access either to the unit's own bank or to the opposite bank. Accesses to a unit's own bank all proceed in parallel in the same cycle.

Each side has only one cross bus in each direction. In one cycle, at most one unit on a side can read from the opposite bank, and at most one unit on a side can write into it. When several units ask for the same cross bus, the lowest-numbered unit wins. Every losing unit gets a denial flag, and its access is dropped.

Each side also has a 64-bit paired-write port, used to land double-word loads in an even/odd register pair. When two accepted writes hit the same register in the same cycle, a conflict flag is raised and the higher-priority write is kept.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset every register in both banks reads as zero, and all flags and read data outputs are zero.
- R2: A unit with its cross select at 0 gets its own bank's register at `rd_addr_i` on `rd_data_o` one clock after the address is applied.
- R3: Among the units of one side whose cross-read select is 1, the lowest-numbered unit gets the opposite bank's register at its address, one clock later.
- R4: Every other unit on that side that requests a cross read in the same cycle gets `xrd_deny_o` set and read data zero one clock later. A unit that does not request a cross read never has `xrd_deny_o` set.
- R5: A local write (`wr_en_i`=1, `wr_cross_i`=0) updates the unit's own bank at the clock edge. A read issued in the following cycle returns the new value.
- R6: Among the units of one side with `wr_en_i`=1 and `wr_cross_i`=1, only the lowest-numbered unit writes into the opposite bank. The others are dropped, and `xwr_deny_o` is set for them one clock later.
- R7: Write priority into a bank, highest first, is: its own units 0 to NPORT-1, then the granted cross write from the other side, then the paired write. When two or more accepted writes target one register, the highest-priority value is stored and `wr_conf_o` for that bank is 1 one clock later.
- R8: A paired write with an even base index stores `dw_data_i[DW-1:0]` into the base register and `dw_data_i[2*DW-1:DW]` into base+1, both at the same edge.
- R9: A paired write with an odd base index changes no register, and `dw_err_o` for that side is 1 one clock later.
- R10: A read in the same cycle as a write to the same register returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr_i | input | 2*NPORT*AW | Read register index per side and unit |
| rd_cross_i | input | 2*NPORT | 1 = read from the opposite bank |
| wr_en_i | input | 2*NPORT | Write enable per side and unit |
| wr_cross_i | input | 2*NPORT | 1 = write into the opposite bank |
| wr_addr_i | input | 2*NPORT*AW | Write register index per side and unit |
| wr_data_i | input | 2*NPORT*DW | Write data per side and unit |
| dw_en_i | input | 2 | Paired-write enable per side |
| dw_addr_i | input | 2*AW | Paired-write base index per side |
| dw_data_i | input | 2*2*DW | Paired-write data, low word to the even register |
| rd_data_o | output | 2*NPORT*DW | Registered read data per side and unit |
| xrd_deny_o | output | 2*NPORT | Cross-read request lost arbitration |
| xwr_deny_o | output | 2*NPORT | Cross-write request lost arbitration |
| wr_conf_o | output | 2 | Two or more writes hit one register of that bank |
| dw_err_o | output | 2 | Paired write with an odd base was rejected |

## Verification
Read data, both denial flags, the conflict flag and the paired-write error are all registered, so each is due exactly one clock after its inputs are applied. A write becomes visible to a read issued in the next cycle, which returns the new value one clock after that.

The bench drives inputs just after a falling edge and predicts every output at that moment from its own register model, using the values held before the writes. It then compares at the next falling edge. Only after that prediction does it update the model with the prioritised writes.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;

    localparam int SIDES = 2;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    function automatic int other_side(input int s);
        return SIDES - 1 - s;
    endfunction

endpackage

// File: rtl/xpath_arb.sv
// Fixed-priority grant for one cross bus: lowest index wins.
module xpath_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic [N-1:0] deny_o
);

    logic taken;

    always_comb begin
        gnt_o = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                gnt_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        deny_o = req_i & ~gnt_o;
    end

endmodule

// File: rtl/rf_bank.sv
// One bank of registers. Writer slot 0 has the highest priority.
module rf_bank #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int NWR  = 7,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NWR-1:0]                 wr_en_i,
    input  logic [NWR-1:0][AW-1:0]         wr_addr_i,
    input  logic [NWR-1:0][DW-1:0]         wr_data_i,
    output logic [NREG-1:0][DW-1:0]        regs_o,
    output logic                           conf_o
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    conf;
    } bank_t;

    bank_t st_d, st_q;
    int    hits;

    always_comb begin
        st_d      = st_q;
        st_d.conf = 1'b0;
        hits      = 0;
        for (int r = 0; r < NREG; r++) begin
            hits = 0;
            // lowest priority applied first so the highest one lands last
            for (int w = NWR - 1; w >= 0; w--) begin
                if (wr_en_i[w] && (wr_addr_i[w] == AW'(r))) begin
                    st_d.regs[r] = wr_data_i[w];
                    hits         = hits + 1;
                end
            end
            if (hits > 1) begin
                st_d.conf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;
    assign conf_o = st_q.conf;

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
    import dbrf_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int NPORT = 4,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [SIDES-1:0][NPORT-1:0][AW-1:0] rd_addr_i,
    input  logic [SIDES-1:0][NPORT-1:0]         rd_cross_i,
    input  logic [SIDES-1:0][NPORT-1:0]         wr_en_i,
    input  logic [SIDES-1:0][NPORT-1:0]         wr_cross_i,
    input  logic [SIDES-1:0][NPORT-1:0][AW-1:0] wr_addr_i,
    input  logic [SIDES-1:0][NPORT-1:0][DW-1:0] wr_data_i,
    input  logic [SIDES-1:0]                    dw_en_i,
    input  logic [SIDES-1:0][AW-1:0]            dw_addr_i,
    input  logic [SIDES-1:0][2*DW-1:0]          dw_data_i,
    output logic [SIDES-1:0][NPORT-1:0][DW-1:0] rd_data_o,
    output logic [SIDES-1:0][NPORT-1:0]         xrd_deny_o,
    output logic [SIDES-1:0][NPORT-1:0]         xwr_deny_o,
    output logic [SIDES-1:0]                    wr_conf_o,
    output logic [SIDES-1:0]                    dw_err_o
);

    // writer slots per bank: own units, one cross write, paired low/high
    localparam int SLOT_X  = NPORT;
    localparam int SLOT_LO = NPORT + 1;
    localparam int SLOT_HI = NPORT + 2;
    localparam int NWR     = NPORT + 3;

    typedef struct packed {
        logic [SIDES-1:0][NPORT-1:0][DW-1:0] rd;
        logic [SIDES-1:0][NPORT-1:0]         xrd_deny;
        logic [SIDES-1:0][NPORT-1:0]         xwr_deny;
        logic [SIDES-1:0]                    dw_err;
    } port_state_t;

    port_state_t out_d, out_q;

    logic [SIDES-1:0][NREG-1:0][DW-1:0] regs;
    logic [SIDES-1:0][NPORT-1:0]        xrd_gnt, xrd_den;
    logic [SIDES-1:0][NPORT-1:0]        xwr_gnt, xwr_den;
    logic [SIDES-1:0][NWR-1:0]          bw_en;
    logic [SIDES-1:0][NWR-1:0][AW-1:0]  bw_addr;
    logic [SIDES-1:0][NWR-1:0][DW-1:0]  bw_data;
    int                                 o;

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        xpath_arb #(.N(NPORT)) u_rd_arb (
            .req_i  (rd_cross_i[s]),
            .gnt_o  (xrd_gnt[s]),
            .deny_o (xrd_den[s])
        );

        xpath_arb #(.N(NPORT)) u_wr_arb (
            .req_i  (wr_en_i[s] & wr_cross_i[s]),
            .gnt_o  (xwr_gnt[s]),
            .deny_o (xwr_den[s])
        );

        rf_bank #(.NREG(NREG), .DW(DW), .NWR(NWR)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (bw_en[s]),
            .wr_addr_i (bw_addr[s]),
            .wr_data_i (bw_data[s]),
            .regs_o    (regs[s]),
            .conf_o    (wr_conf_o[s])
        );
    end

    always_comb begin
        out_d   = out_q;
        bw_en   = '0;
        bw_addr = '0;
        bw_data = '0;
        o       = 0;
        for (int s = 0; s < SIDES; s++) begin
            o = other_side(s);
            for (int u = 0; u < NPORT; u++) begin
                // read path: values held before this cycle's writes
                if (rd_cross_i[s][u]) begin
                    out_d.rd[s][u] = xrd_gnt[s][u] ? regs[o][rd_addr_i[s][u]] : '0;
                end else begin
                    out_d.rd[s][u] = regs[s][rd_addr_i[s][u]];
                end
                // local write slot
                bw_en[s][u]   = wr_en_i[s][u] & ~wr_cross_i[s][u];
                bw_addr[s][u] = wr_addr_i[s][u];
                bw_data[s][u] = wr_data_i[s][u];
                // single cross-write bus into the opposite bank
                if (xwr_gnt[s][u]) begin
                    bw_en[o][SLOT_X]   = 1'b1;
                    bw_addr[o][SLOT_X] = wr_addr_i[s][u];
                    bw_data[o][SLOT_X] = wr_data_i[s][u];
                end
            end
            // paired write into an even/odd pair
            if (dw_en_i[s] && !dw_addr_i[s][0]) begin
                bw_en[s][SLOT_LO]   = 1'b1;
                bw_addr[s][SLOT_LO] = dw_addr_i[s];
                bw_data[s][SLOT_LO] = dw_data_i[s][DW-1:0];
                bw_en[s][SLOT_HI]   = 1'b1;
                bw_addr[s][SLOT_HI] = dw_addr_i[s] | AW'(1);
                bw_data[s][SLOT_HI] = dw_data_i[s][2*DW-1:DW];
            end
            out_d.xrd_deny[s] = xrd_den[s];
            out_d.xwr_deny[s] = xwr_den[s];
            out_d.dw_err[s]   = dw_en_i[s] & dw_addr_i[s][0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rd_data_o  = out_q.rd;
    assign xrd_deny_o = out_q.xrd_deny;
    assign xwr_deny_o = out_q.xwr_deny;
    assign dw_err_o   = out_q.dw_err;

endmodule

// File: rtl/dbrf_checker.sv
module dbrf_checker
    import dbrf_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int NPORT = 4,
    localparam int AW   = $clog2(NREG)
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [SIDES-1:0][NPORT-1:0][AW-1:0] rd_addr_i,
    input logic [SIDES-1:0][NPORT-1:0]         rd_cross_i,
    input logic [SIDES-1:0][NPORT-1:0]         wr_en_i,
    input logic [SIDES-1:0][NPORT-1:0]         wr_cross_i,
    input logic [SIDES-1:0][NPORT-1:0][AW-1:0] wr_addr_i,
    input logic [SIDES-1:0]                    dw_en_i,
    input logic [SIDES-1:0][AW-1:0]            dw_addr_i,
    input logic [SIDES-1:0][NPORT-1:0][DW-1:0] rd_data_o,
    input logic [SIDES-1:0][NPORT-1:0]         xrd_deny_o,
    input logic [SIDES-1:0][NPORT-1:0]         xwr_deny_o,
    input logic [SIDES-1:0]                    wr_conf_o,
    input logic [SIDES-1:0]                    dw_err_o
);

    for (genvar s = 0; s < SIDES; s++) begin : g_chk
        p_xrd_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_cross_i[s] != '0) |=>
            ($countones(xrd_deny_o[s]) == $countones($past(rd_cross_i[s])) - 1));

        p_xrd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_cross_i[s][0] |=> !xrd_deny_o[s][0]);

        p_xwr_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((wr_en_i[s] & wr_cross_i[s]) != '0) |=>
            ($countones(xwr_deny_o[s]) == $countones($past(wr_en_i[s] & wr_cross_i[s])) - 1));

        p_odd_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (dw_en_i[s] && dw_addr_i[s][0]) |=> dw_err_o[s]);

        p_even_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(dw_en_i[s] && dw_addr_i[s][0]) |=> !dw_err_o[s]);

        p_same_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i[s][0] && wr_en_i[s][1] && !wr_cross_i[s][0] && !wr_cross_i[s][1]
             && (wr_addr_i[s][0] == wr_addr_i[s][1])) |=> wr_conf_o[s]);

        for (genvar u = 0; u < NPORT; u++) begin : g_unit
            p_deny_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
                xrd_deny_o[s][u] |-> (rd_data_o[s][u] == '0));

            p_no_req_no_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_cross_i[s][u] |=> !xrd_deny_o[s][u]);
        end
    end

endmodule

bind dual_bank_regfile dbrf_checker #(
    .NREG  (NREG),
    .DW    (DW),
    .NPORT (NPORT)
) u_dbrf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr_i  (rd_addr_i),
    .rd_cross_i (rd_cross_i),
    .wr_en_i    (wr_en_i),
    .wr_cross_i (wr_cross_i),
    .wr_addr_i  (wr_addr_i),
    .dw_en_i    (dw_en_i),
    .dw_addr_i  (dw_addr_i),
    .rd_data_o  (rd_data_o),
    .xrd_deny_o (xrd_deny_o),
    .xwr_deny_o (xwr_deny_o),
    .wr_conf_o  (wr_conf_o),
    .dw_err_o   (dw_err_o)
);

// File: tb/dual_bank_regfile_test.sv
`timescale 1ns/1ps
module dual_bank_regfile_test;

    localparam int NREG  = 16;
    localparam int DW    = 32;
    localparam int NPORT = 4;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0][NPORT-1:0][AW-1:0] rd_addr, wr_addr;
    logic [1:0][NPORT-1:0]         rd_cross, wr_en, wr_cross;
    logic [1:0][NPORT-1:0][DW-1:0] wr_data;
    logic [1:0]                    dw_en;
    logic [1:0][AW-1:0]            dw_addr;
    logic [1:0][2*DW-1:0]          dw_data;
    logic [1:0][NPORT-1:0][DW-1:0] rd_data;
    logic [1:0][NPORT-1:0]         xrd_deny, xwr_deny;
    logic [1:0]                    wr_conf, dw_err;

    dual_bank_regfile #(.NREG(NREG), .DW(DW), .NPORT(NPORT)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_i(rd_addr), .rd_cross_i(rd_cross),
        .wr_en_i(wr_en), .wr_cross_i(wr_cross),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .dw_en_i(dw_en), .dw_addr_i(dw_addr), .dw_data_i(dw_data),
        .rd_data_o(rd_data), .xrd_deny_o(xrd_deny), .xwr_deny_o(xwr_deny),
        .wr_conf_o(wr_conf), .dw_err_o(dw_err)
    );

    logic [DW-1:0] model [2][NREG];
    logic [DW-1:0] nm    [2][NREG];
    int            hits  [2][NREG];
    logic [DW-1:0] e_rd  [2][NPORT];
    logic          e_xrd [2][NPORT];
    logic          e_xwr [2][NPORT];
    string         e_tag [2][NPORT];
    logic          e_wc  [2];
    logic          e_de  [2];
    int            vectors = 0;
    int            errors  = 0;
    bit            done    = 1'b0;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(int t, logic [AW-1:0] a, logic [DW-1:0] d);
        if (hits[t][a] == 0) nm[t][a] = d;
        hits[t][a]++;
    endtask

    task automatic idle();
        rd_addr = '0; rd_cross = '0; wr_en = '0; wr_cross = '0;
        wr_addr = '0; wr_data = '0; dw_en = '0; dw_addr = '0; dw_data = '0;
    endtask

    // expected outputs from the current inputs, then model update
    task automatic predict(string tag);
        int first;
        for (int s = 0; s < 2; s++) begin
            first = -1;
            for (int u = 0; u < NPORT; u++) begin
                e_xrd[s][u] = 1'b0;
                if (rd_cross[s][u]) begin
                    if (first < 0) begin
                        first = u;
                        e_rd[s][u] = model[1-s][rd_addr[s][u]];
                        e_tag[s][u] = "R3";
                    end else begin
                        e_rd[s][u] = '0;
                        e_xrd[s][u] = 1'b1;
                        e_tag[s][u] = "R4";
                    end
                end else begin
                    e_rd[s][u] = model[s][rd_addr[s][u]];
                    e_tag[s][u] = "R2";
                end
                if (tag != "") e_tag[s][u] = tag;
            end
        end
        for (int t = 0; t < 2; t++)
            for (int r = 0; r < NREG; r++) begin
                nm[t][r] = model[t][r];
                hits[t][r] = 0;
            end
        for (int t = 0; t < 2; t++) begin
            for (int u = 0; u < NPORT; u++)
                if (wr_en[t][u] && !wr_cross[t][u]) put(t, wr_addr[t][u], wr_data[t][u]);
            first = -1;
            for (int u = 0; u < NPORT; u++) begin
                e_xwr[1-t][u] = 1'b0;
                if (wr_en[1-t][u] && wr_cross[1-t][u]) begin
                    if (first < 0) begin
                        first = u;
                        put(t, wr_addr[1-t][u], wr_data[1-t][u]);
                    end else begin
                        e_xwr[1-t][u] = 1'b1;
                    end
                end
            end
            if (dw_en[t] && !dw_addr[t][0]) begin
                put(t, dw_addr[t], dw_data[t][DW-1:0]);
                put(t, dw_addr[t] | 4'd1, dw_data[t][2*DW-1:DW]);
            end
            e_wc[t] = 1'b0;
            for (int r = 0; r < NREG; r++) if (hits[t][r] > 1) e_wc[t] = 1'b1;
            e_de[t] = dw_en[t] && dw_addr[t][0];
        end
        for (int t = 0; t < 2; t++)
            for (int r = 0; r < NREG; r++) model[t][r] = nm[t][r];
    endtask

    task automatic cycle(string tag);
        predict(tag);
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            for (int u = 0; u < NPORT; u++) begin
                chk(e_tag[s][u], $sformatf("rd_data[%0d][%0d]", s, u), 64'(rd_data[s][u]), 64'(e_rd[s][u]));
                chk("R4", $sformatf("xrd_deny[%0d][%0d]", s, u), 64'(xrd_deny[s][u]), 64'(e_xrd[s][u]));
                chk("R6", $sformatf("xwr_deny[%0d][%0d]", s, u), 64'(xwr_deny[s][u]), 64'(e_xwr[s][u]));
            end
            chk("R7", $sformatf("wr_conf[%0d]", s), 64'(wr_conf[s]), 64'(e_wc[s]));
            chk("R9", $sformatf("dw_err[%0d]", s), 64'(dw_err[s]), 64'(e_de[s]));
        end
        idle();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240613));
        for (int t = 0; t < 2; t++)
            for (int r = 0; r < NREG; r++) model[t][r] = '0;
        idle();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero straight out of reset
        for (int r = 0; r < NREG; r += NPORT) begin
            for (int s = 0; s < 2; s++)
                for (int u = 0; u < NPORT; u++) rd_addr[s][u] = AW'(r + u);
            cycle("R1");
        end

        // R5: local write then read back
        wr_en[0][2] = 1'b1; wr_addr[0][2] = 4'd7; wr_data[0][2] = 32'hA5A5_0007;
        cycle("R5");
        rd_addr[0][0] = 4'd7;
        cycle("R5");

        // R10: read and write the same register in one cycle
        wr_en[0][1] = 1'b1; wr_addr[0][1] = 4'd7; wr_data[0][1] = 32'h1234_5678;
        rd_addr[0][0] = 4'd7; rd_addr[0][3] = 4'd7;
        cycle("R10");

        // R8: paired write into B14/B15, then read locally and across
        dw_en[1] = 1'b1; dw_addr[1] = 4'd14; dw_data[1] = 64'hDEAD_BEEF_0BAD_F00D;
        cycle("R8");
        rd_addr[1][0] = 4'd14; rd_addr[1][1] = 4'd15;
        rd_cross[0][3] = 1'b1; rd_addr[0][3] = 4'd15;
        cycle("R8");

        // R9: odd base rejected, register 5 untouched
        wr_en[0][0] = 1'b1; wr_addr[0][0] = 4'd5; wr_data[0][0] = 32'h0000_0555;
        cycle("R9");
        dw_en[0] = 1'b1; dw_addr[0] = 4'd5; dw_data[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        cycle("R9");
        rd_addr[0][0] = 4'd5; rd_addr[0][1] = 4'd4; rd_addr[0][2] = 4'd6;
        cycle("R9");

        // R7: units 0 and 3 plus a cross write all hit A2
        wr_en[0][0] = 1'b1; wr_addr[0][0] = 4'd2; wr_data[0][0] = 32'h0000_AAAA;
        wr_en[0][3] = 1'b1; wr_addr[0][3] = 4'd2; wr_data[0][3] = 32'h0000_BBBB;
        wr_en[1][1] = 1'b1; wr_cross[1][1] = 1'b1; wr_addr[1][1] = 4'd2; wr_data[1][1] = 32'hCCCC;
        wr_en[1][2] = 1'b1; wr_cross[1][2] = 1'b1; wr_addr[1][2] = 4'd9; wr_data[1][2] = 32'hDDDD;
        cycle("R7");
        rd_addr[0][0] = 4'd2; rd_addr[0][1] = 4'd9;
        cycle("R7");

        // R6: cross write lands in the opposite bank
        wr_en[0][1] = 1'b1; wr_cross[0][1] = 1'b1; wr_addr[0][1] = 4'd11; wr_data[0][1] = 32'h6666;
        cycle("R6");
        rd_addr[1][2] = 4'd11; rd_cross[0][0] = 1'b1; rd_cross[0][2] = 1'b1; rd_addr[0][0] = 4'd11;
        cycle("");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            for (int s = 0; s < 2; s++) begin
                for (int u = 0; u < NPORT; u++) begin
                    rd_addr[s][u]  = AW'($urandom % NREG);
                    rd_cross[s][u] = ($urandom % 3) == 0;
                    wr_en[s][u]    = ($urandom % 2) == 0;
                    wr_cross[s][u] = ($urandom % 4) == 0;
                    wr_addr[s][u]  = AW'(($urandom % 2) ? ($urandom % 4) : ($urandom % NREG));
                    wr_data[s][u]  = $urandom;
                end
                dw_en[s]   = ($urandom % 4) == 0;
                dw_addr[s] = AW'($urandom % NREG);
                dw_data[s] = {$urandom, $urandom};
            end
            cycle("");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule